// File: doc/BRIEF.md
# Double-Buffered Serial CODEC Register Interface

This block sits on a 16-bit processor bus and trades 16-bit words with an external serial CODEC. It has two data channels, each reached at its own bus address. Every channel owns a transfer register and a holding register. During a serial frame, the transfer register sends its contents out on the channel's transmit pin, most significant bit first. In the same frame it takes in the bits that arrive on the receive pin. The processor only ever reads the holding register.

One write to a channel address does two jobs in the same cycle. The word just received moves into the holding register, and the new outgoing word goes into the transfer register. Software therefore waits for the end-of-frame interrupt, writes the next outgoing word, and then reads back the word that arrived. A third address holds two chained configuration registers. Each write pushes the previous wait-state value into the frame-period timer and stores the new word as the wait-state value. Two writes in a row, timer value first, load both registers.

The block divides the system clock to make the serial clock and produces a one-clock frame-sync pulse. It raises an interrupt when the last data bit of a frame has been sampled. When the block is disabled, serial activity stops and its three addresses become plain external-bus addresses.

Top module: `sercodec_dbuf`

## Requirements
- R1: After reset, irq, overrun, sclk, fsync and both transmit pins are 0, and reads of the channel and configuration addresses return 0.
- R2: While enabled, sclk toggles every SCLK_HALF system clocks, so one serial clock lasts 2*SCLK_HALF system clocks.
- R3: A frame is one serial clock with fsync high followed by 16 data serial clocks. Transmit bits go out MSB first and change on the sclk rising edge. Receive bits are sampled MSB first on the falling edge. fsync repeats every max(timer,17) serial clocks.
- R4: An accepted write to a channel copies the transfer register into the holding register and loads the written word into the transfer register. The next frame then sends that word.
- R5: With channel 0 at address 5, a write after irq followed by a read returns the word received on rx_i[0] in the frame that just ended.
- R6: Channel 1 at address 6 behaves like channel 0, using rx_i[1] and tx_o[1], independently of channel 0.
- R7: A write to address 7 moves the previous wait-state value into the timer and stores the written word as the wait-state value. A read of address 7 returns the timer, and wait_cnt shows the wait-state value.
- R8: irq goes to 1 after the last receive bit of a frame is sampled. It stays at 1 until an accepted channel write clears it.
- R9: A channel write while a frame is shifting sets overrun, which stays set until reset. That write changes neither register and does not clear irq.
- R10: While enable is 0: sclk, fsync and tx_o stay 0; irq is 0; writes to addresses 5 to 7 change nothing; reads of those addresses return ext_rdata; ext_strobe is 1 on any access to them.
- R11: Reads of any address other than 5 to 7 return ext_rdata, and ext_strobe stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | 1 runs the serial interface, 0 turns the addresses over to the external bus |
| bus_addr | input | 3 | Bus address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data |
| ext_rdata | input | 16 | External-bus read data |
| ext_strobe | output | 1 | Access to a block address while disabled |
| rx_i | input | 2 | Serial receive pin, one per channel |
| tx_o | output | 2 | Serial transmit pin, one per channel |
| sclk | output | 1 | Serial clock |
| fsync | output | 1 | Frame-sync pulse, one serial clock long |
| irq | output | 1 | End-of-frame interrupt |
| overrun | output | 1 | Sticky flag for a write made during shifting |
| wait_cnt | output | 16 | Wait-state register |

## Verification
The bench builds the block with SCLK_HALF=2, two channels and the addresses 5, 6 and 7. This makes a serial clock four system clocks long and a minimum frame 68 cycles long, so many complete frames fit in one run. With these values the bench reaches the clamp at 17 serial clocks, a random longer period, writes made in the middle of a frame, and stretches of disabled operation. A CODEC model in the bench feeds random words into both receive pins and collects the transmitted words for comparison.

// File: rtl/sercodec_pkg.sv
package sercodec_pkg;

    localparam int WORD_W     = 16;
    localparam int FRAME_BITS = 16;
    localparam int MIN_PERIOD = FRAME_BITS + 1;

    typedef logic [WORD_W-1:0] word_t;

    // one data channel: readable holding stage and shifting transfer stage
    typedef struct packed {
        word_t hold;
        word_t xfer;
    } dbuf_t;

    // chained configuration pair
    typedef struct packed {
        word_t timer;
        word_t waits;
    } cfg_t;

    // last serial-clock position of a frame, with the minimum period enforced
    function automatic word_t frame_last_pos(input word_t timer);
        if (timer < word_t'(MIN_PERIOD))
            return word_t'(MIN_PERIOD - 1);
        return timer - word_t'(1);
    endfunction

endpackage

// File: rtl/sercodec_framer.sv
module sercodec_framer
    import sercodec_pkg::*;
#(
    parameter int SCLK_HALF = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  en,
    input  word_t last_pos,
    output logic  sclk,
    output logic  fsync,
    output logic  busy,
    output logic  tx_load,
    output logic  tx_clear,
    output logic  rx_shift,
    output logic  frame_end
);

    localparam int DIV_W = (SCLK_HALF > 1) ? $clog2(SCLK_HALF) : 1;

    logic [DIV_W-1:0] div_cnt;
    word_t            pos;
    word_t            pos_nxt;
    logic             div_wrap;
    logic             rise_tk;
    logic             fall_tk;
    logic             data_nxt;

    assign div_wrap = (div_cnt == DIV_W'(SCLK_HALF - 1));
    assign rise_tk  = en && div_wrap && !sclk;
    assign fall_tk  = en && div_wrap && sclk;

    always_comb begin
        if (pos == '1 || pos >= last_pos)
            pos_nxt = '0;
        else
            pos_nxt = pos + word_t'(1);
    end

    assign data_nxt  = (pos_nxt != '0) && (pos_nxt <= word_t'(FRAME_BITS));
    assign tx_load   = rise_tk && data_nxt;
    assign tx_clear  = rise_tk && !data_nxt;
    assign rx_shift  = fall_tk && busy;
    assign frame_end = fall_tk && busy && (pos == word_t'(FRAME_BITS));
    assign fsync     = (pos == '0);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            div_cnt <= '0;
            sclk    <= 1'b0;
            pos     <= '1;
            busy    <= 1'b0;
        end else begin
            div_cnt <= div_wrap ? '0 : div_cnt + DIV_W'(1);
            if (div_wrap)
                sclk <= ~sclk;
            if (rise_tk) begin
                pos <= pos_nxt;
                if (pos_nxt == word_t'(1))
                    busy <= 1'b1;
            end
            if (frame_end)
                busy <= 1'b0;
        end
    end

    AST_SYNC_OUTSIDE_DATA: assert property (@(posedge clk) disable iff (rst)
        fsync |-> !busy);                                              // R3
    AST_FRAME_CLOSES: assert property (@(posedge clk) disable iff (rst)
        frame_end |=> !busy);                                          // R3
    AST_SCLK_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (en && $past(en) && !$past(div_wrap)) |-> $stable(sclk));      // R2

endmodule

// File: rtl/sercodec_chan.sv
module sercodec_chan
    import sercodec_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  en,
    input  logic  load,
    input  word_t wdata,
    input  logic  tx_load,
    input  logic  tx_clear,
    input  logic  rx_shift,
    input  logic  rx,
    output word_t hold,
    output logic  tx
);

    dbuf_t r;

    always_ff @(posedge clk) begin
        if (rst) begin
            r  <= '0;
            tx <= 1'b0;
        end else begin
            if (load) begin
                r.hold <= r.xfer;
                r.xfer <= wdata;
            end else if (rx_shift) begin
                r.xfer <= {r.xfer[WORD_W-2:0], rx};
            end
            if (!en)
                tx <= 1'b0;
            else if (tx_load)
                tx <= r.xfer[WORD_W-1];
            else if (tx_clear)
                tx <= 1'b0;
        end
    end

    assign hold = r.hold;

    AST_LOAD_PUSHES: assert property (@(posedge clk) disable iff (rst)
        load |=> (r.hold == $past(r.xfer)));                           // R4
    AST_NO_LOAD_WHILE_SHIFT: assert property (@(posedge clk) disable iff (rst)
        load |-> !rx_shift);                                           // R9
    AST_TX_QUIET_OFF: assert property (@(posedge clk) disable iff (rst)
        !en |=> !tx);                                                  // R10

endmodule

// File: rtl/sercodec_cfg.sv
module sercodec_cfg
    import sercodec_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  word_t wdata,
    output word_t timer,
    output word_t waits
);

    cfg_t c;

    always_ff @(posedge clk) begin
        if (rst) begin
            c <= '0;
        end else if (load) begin
            c.timer <= c.waits;
            c.waits <= wdata;
        end
    end

    assign timer = c.timer;
    assign waits = c.waits;

    AST_CFG_CHAIN: assert property (@(posedge clk) disable iff (rst)
        load |=> (timer == $past(waits)));                             // R7
    AST_CFG_KEEP: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(c));                                         // R7

endmodule

// File: rtl/sercodec_dbuf.sv
module sercodec_dbuf
    import sercodec_pkg::*;
#(
    parameter int ADDR_W    = 3,
    parameter int NUM_CH    = 2,
    parameter int CH_BASE   = 5,
    parameter int CFG_ADDR  = 7,
    parameter int SCLK_HALF = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    input  logic [15:0]       ext_rdata,
    output logic              ext_strobe,
    input  logic [NUM_CH-1:0] rx_i,
    output logic [NUM_CH-1:0] tx_o,
    output logic              sclk,
    output logic              fsync,
    output logic              irq,
    output logic              overrun,
    output logic [15:0]       wait_cnt
);

    logic [NUM_CH-1:0] hit_ch;
    logic [NUM_CH-1:0] load_ch;
    word_t             hold_w [NUM_CH];
    logic              hit_cfg;
    logic              any_hit;
    logic              wr_ch;
    logic              accept;
    logic              cfg_load;
    word_t             timer;
    logic              busy;
    logic              tx_load;
    logic              tx_clear;
    logic              rx_shift;
    logic              frame_end;

    assign hit_cfg  = (bus_addr == ADDR_W'(CFG_ADDR));
    assign any_hit  = (|hit_ch) || hit_cfg;
    assign wr_ch    = bus_wr && enable && (|hit_ch);
    assign accept   = wr_ch && !busy;
    assign cfg_load = bus_wr && enable && hit_cfg;

    sercodec_framer #(.SCLK_HALF(SCLK_HALF)) u_framer (
        .clk      (clk),
        .rst      (rst),
        .en       (enable),
        .last_pos (frame_last_pos(timer)),
        .sclk     (sclk),
        .fsync    (fsync),
        .busy     (busy),
        .tx_load  (tx_load),
        .tx_clear (tx_clear),
        .rx_shift (rx_shift),
        .frame_end(frame_end)
    );

    sercodec_cfg u_cfg (
        .clk  (clk),
        .rst  (rst),
        .load (cfg_load),
        .wdata(bus_wdata),
        .timer(timer),
        .waits(wait_cnt)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        assign hit_ch[i]  = (bus_addr == ADDR_W'(CH_BASE + i));
        assign load_ch[i] = accept && hit_ch[i];

        sercodec_chan u_chan (
            .clk     (clk),
            .rst     (rst),
            .en      (enable),
            .load    (load_ch[i]),
            .wdata   (bus_wdata),
            .tx_load (tx_load),
            .tx_clear(tx_clear),
            .rx_shift(rx_shift),
            .rx      (rx_i[i]),
            .hold    (hold_w[i]),
            .tx      (tx_o[i])
        );
    end

    always_comb begin
        bus_rdata = ext_rdata;
        if (enable) begin
            for (int i = 0; i < NUM_CH; i++)
                if (hit_ch[i])
                    bus_rdata = hold_w[i];
            if (hit_cfg)
                bus_rdata = timer;
        end
    end

    assign ext_strobe = !enable && any_hit && (bus_wr || bus_rd);

    always_ff @(posedge clk) begin
        if (rst) begin
            irq     <= 1'b0;
            overrun <= 1'b0;
        end else begin
            if (!enable)
                irq <= 1'b0;
            else if (frame_end)
                irq <= 1'b1;
            else if (accept)
                irq <= 1'b0;
            if (wr_ch && busy)
                overrun <= 1'b1;
        end
    end

    AST_IRQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (enable && irq && !accept) |=> irq);                           // R8
    AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (rst)
        overrun |=> overrun);                                          // R9
    AST_BUSY_WRITE_FLAGGED: assert property (@(posedge clk) disable iff (rst)
        (wr_ch && busy) |=> overrun);                                  // R9
    AST_OFF_SILENT: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (!sclk && !fsync && !irq));                        // R10
    AST_ONE_CHANNEL: assert property (@(posedge clk) disable iff (rst)
        $onehot0(load_ch));                                            // R6

endmodule

// File: tb/test_sercodec_dbuf.sv
module test_sercodec_dbuf;

    localparam int SH = 2;

    logic        clk = 1'b0;
    logic        rst;
    logic        enable;
    logic [2:0]  bus_addr;
    logic        bus_wr;
    logic        bus_rd;
    logic [15:0] bus_wdata;
    logic [15:0] bus_rdata;
    logic [15:0] ext_rdata;
    logic        ext_strobe;
    logic [1:0]  rx_i;
    logic [1:0]  tx_o;
    logic        sclk;
    logic        fsync;
    logic        irq;
    logic        overrun;
    logic [15:0] wait_cnt;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #4 clk = ~clk;

    sercodec_dbuf #(.SCLK_HALF(SH)) i_sercodec_dbuf (
        .clk(clk), .rst(rst), .enable(enable), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .ext_rdata(ext_rdata), .ext_strobe(ext_strobe),
        .rx_i(rx_i), .tx_o(tx_o), .sclk(sclk), .fsync(fsync), .irq(irq),
        .overrun(overrun), .wait_cnt(wait_cnt)
    );

    // CODEC model: drives rx on sclk rise, collects tx bits
    logic        prev_sclk = 1'b0;
    bit          inframe   = 0;
    int          bidx      = 0;
    int          frames    = 0;
    logic [15:0] cur_rx [2];
    logic [15:0] acc_tx [2];
    logic [15:0] done_rx [2];
    logic [15:0] done_tx [2];

    always @(negedge clk) begin
        if (sclk && !prev_sclk) begin
            if (fsync) begin
                inframe   = 1;
                bidx      = 0;
                cur_rx[0] = 16'($urandom);
                cur_rx[1] = 16'($urandom);
            end else if (inframe) begin
                for (int c = 0; c < 2; c++) begin
                    rx_i[c]   = cur_rx[c][15-bidx];
                    acc_tx[c] = {acc_tx[c][14:0], tx_o[c]};
                end
                bidx++;
                if (bidx == 16) begin
                    inframe = 0;
                    for (int c = 0; c < 2; c++) begin
                        done_rx[c] = cur_rx[c];
                        done_tx[c] = acc_tx[c];
                    end
                    frames++;
                end
            end
        end
        prev_sclk = sclk;
    end

    function automatic int exp_period(input int timer);
        return ((timer < 17) ? 17 : timer) * 2 * SH;
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d, output logic s);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1;
        d = bus_rdata; s = ext_strobe;
        bus_rd = 1'b0;
    endtask

    task automatic wait_frame();
        int f = frames;
        while (frames == f) @(negedge clk);
        while (!irq) @(negedge clk);
    endtask

    task automatic measure_fsync(output int cyc);
        logic p;
        p = fsync;
        @(negedge clk);
        while (!(fsync && !p)) begin p = fsync; @(negedge clk); end
        cyc = 0;
        p = fsync;
        @(negedge clk); cyc++;
        while (!(fsync && !p)) begin p = fsync; @(negedge clk); cyc++; end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] d, sent[2], nw[2], held0;
        logic        s;
        int          cyc, t;
        void'($urandom(32'h1c0dec));
        rst = 1; enable = 0; bus_addr = 0; bus_wr = 0; bus_rd = 0;
        bus_wdata = 0; ext_rdata = 16'hBEEF; rx_i = 0;
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check("R1", "irq", irq, 0);
        check("R1", "overrun", overrun, 0);
        check("R1", "sclk/fsync/tx", {sclk, fsync, tx_o}, 0);
        enable = 1;
        rd(3'd5, d, s); check("R1", "ch0 read", d, 0);
        rd(3'd7, d, s); check("R1", "cfg read", d, 0);

        // R7 configuration chain
        wr(3'd7, 16'd20); wr(3'd7, 16'd9);
        rd(3'd7, d, s); check("R7", "timer", d, 20);
        check("R7", "wait_cnt", wait_cnt, 9);

        // R2 serial clock period
        while (sclk) @(negedge clk);
        while (!sclk) @(negedge clk);
        cyc = 0;
        while (sclk) begin @(negedge clk); cyc++; end
        while (!sclk) begin @(negedge clk); cyc++; end
        check("R2", "sclk period", cyc, 2 * SH);

        // R3 frame period
        measure_fsync(cyc); measure_fsync(cyc);
        check("R3", "frame period 20", cyc, exp_period(20));

        // R4 R5 R6 R8 data exchange
        for (int k = 0; k < 20; k++) begin
            wait_frame();
            check("R8", "irq at frame end", irq, 1);
            if (k > 0) begin
                check("R3", "tx ch0 msb first", done_tx[0], sent[0]);
                check("R6", "tx ch1", done_tx[1], sent[1]);
            end
            if (k == 5) begin
                repeat (3) @(negedge clk);
                check("R8", "irq held", irq, 1);
            end
            nw[0] = 16'($urandom); nw[1] = 16'($urandom);
            if (k == 7) begin nw[0] = 16'h8000; nw[1] = 16'h0001; end
            wr(3'd5, nw[0]);
            check("R8", "irq cleared", irq, 0);
            wr(3'd6, nw[1]);
            rd(3'd5, d, s); check("R5", "ch0 received", d, done_rx[0]);
            rd(3'd6, d, s); check("R6", "ch1 received", d, done_rx[1]);
            sent[0] = nw[0]; sent[1] = nw[1];
        end

        // R9 write during shifting
        rd(3'd5, held0, s);
        while (!fsync) @(negedge clk);
        while (fsync) @(negedge clk);
        repeat (3 * 2 * SH) @(negedge clk);
        wr(3'd5, 16'hDEAD);
        check("R9", "overrun set", overrun, 1);
        rd(3'd5, d, s); check("R9", "hold unchanged", d, held0);
        wait_frame();
        check("R9", "tx unaffected", done_tx[0], sent[0]);
        wr(3'd5, 16'h1357); wr(3'd6, 16'h2468);
        rd(3'd5, d, s); check("R9", "ch0 after overrun", d, done_rx[0]);
        sent[0] = 16'h1357; sent[1] = 16'h2468;
        wait_frame();
        check("R4", "loaded word sent", done_tx[0], sent[0]);

        // R3 clamp and random period
        wr(3'd7, 16'd3); wr(3'd7, 16'd4);
        measure_fsync(cyc); measure_fsync(cyc);
        check("R3", "clamped period", cyc, exp_period(3));
        t = 18 + ($urandom % 30);
        wr(3'd7, 16'(t)); wr(3'd7, 16'd1);
        measure_fsync(cyc); measure_fsync(cyc);
        check("R3", "random period", cyc, exp_period(t));

        // R10 disabled
        rd(3'd5, held0, s);
        @(negedge clk); enable = 0;
        @(negedge clk);
        begin
            bit quiet = 1;
            for (int i = 0; i < 40; i++) begin
                @(negedge clk);
                if (sclk || fsync || tx_o != 0 || irq) quiet = 0;
            end
            check("R10", "quiet when off", quiet, 1);
        end
        rd(3'd5, d, s);
        check("R10", "ext read data", d, 16'hBEEF);
        check("R10", "ext strobe", s, 1);
        wr(3'd5, 16'h4242); wr(3'd7, 16'h0077);
        check("R10", "wait_cnt unchanged", wait_cnt, 16'd1);
        enable = 1;
        rd(3'd5, d, s); check("R10", "hold kept", d, held0);

        // R11 foreign address
        ext_rdata = 16'h5A5A;
        rd(3'd4, d, s);
        check("R11", "foreign read", d, 16'h5A5A);
        check("R11", "no strobe", s, 0);
        check("R9", "overrun sticky", overrun, 1);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule